// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block gathers the interrupt events of a serial port peripheral into one latched status word, filters that word through a software-written enable mask, and drives six interrupt lines. Event sources elsewhere in the peripheral, such as the receive FIFO, the receive timeout counter and the modem pins, pulse a set input. The set bit then stays latched until software clears it. A pulse that marks a write to the transmit data register latches the transmit status bit.

Software reaches the unit through a small register window. One address returns the latched status and is read-only. Another holds the enable mask. A third returns the status ANDed with the mask and ignores writes. The last is a write-one-to-clear port that always reads as zero. Output line 0 is the OR of every enabled source. Lines 1 to 5 each cover one source group.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While rst_n is low, the latched status, the enable mask and all six output lines are zero.
- R2: A 1 on evt_set[k] latches status bit k, and the bit stays set until it is cleared. Bit meaning: 0 ring, 1 CTS, 2 DCD, 3 DSR, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun.
- R3: A cycle with data_wr high latches status bit 5 (transmit).
- R4: A write with addr 1 loads the enable mask from wdata. Reading addr 1 returns the mask.
- R5: Reading addr 0 returns the latched status. Reading addr 2 returns the latched status ANDed with the mask.
- R6: A write with addr 3 clears every status bit whose wdata bit is 1 and leaves the other bits unchanged. Reading addr 3 always returns zero.
- R7: Writes with addr 0 or addr 2 change neither the status nor the mask.
- R8: When the same bit is set by evt_set (or data_wr) and cleared in the same cycle, the set takes effect and the bit ends up 1.
- R9: irq_o[1] to irq_o[5] are the masked groups, in this order: receive (bit 4), transmit (bit 5), receive timeout (bit 6), modem status (bits 0 to 3) and error (bits 7 to 10).
- R10: irq_o[0] is high exactly when any masked status bit is high, so it equals the OR of irq_o[5:1].
- R11: The output lines are registered. They follow a change in status or mask one clock edge after that register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 status, 1 mask, 2 masked, 3 clear |
| wdata | input | 11 | Write data |
| rdata | output | 11 | Read data for addr, combinational |
| evt_set | input | 11 | One-cycle set pulses from event sources |
| data_wr | input | 1 | Pulse marking a transmit data register write |
| irq_o | output | 6 | Line 0 combined, lines 1 to 5 group interrupts |

## Verification
A write or event presented before clock edge N shows up in the status, mask and masked read values just after edge N. The interrupt lines follow one edge later, at N+1. The bench drives its stimulus on the falling edge and removes it on the next falling edge. It then waits one more falling edge and only after that reads the registers and the lines, so every value is sampled after both edges. A directed test checks the lines at the intermediate falling edge, where they must still show their old value, and again one cycle later.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int NSRC = 11,
  parameter int TX_BIT = 5,
  parameter logic [NSRC-1:0] RX_GRP  = 11'h010,
  parameter logic [NSRC-1:0] TX_GRP  = 11'h020,
  parameter logic [NSRC-1:0] RT_GRP  = 11'h040,
  parameter logic [NSRC-1:0] MS_GRP  = 11'h00F,
  parameter logic [NSRC-1:0] ERR_GRP = 11'h780
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  input  logic [NSRC-1:0] evt_set,
  input  logic            data_wr,
  output logic [5:0]      irq_o
);

  localparam logic [1:0] A_RAW = 2'd0;
  localparam logic [1:0] A_MSK = 2'd1;
  localparam logic [1:0] A_MIS = 2'd2;
  localparam logic [1:0] A_CLR = 2'd3;
  localparam logic [NSRC-1:0] ALL_GRP = RX_GRP | TX_GRP | RT_GRP | MS_GRP | ERR_GRP;
  localparam logic [NSRC-1:0] LINE_GRP [6] = '{ALL_GRP, RX_GRP, TX_GRP, RT_GRP, MS_GRP, ERR_GRP};

  logic [NSRC-1:0] raw_q, mask_q, clr_bits, set_bits, masked;
  logic [5:0]      irq_d;

  assign clr_bits = (wr_en && addr == A_CLR) ? wdata : '0;
  assign set_bits = evt_set | (data_wr ? NSRC'(1) << TX_BIT : '0);
  assign masked   = raw_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | set_bits;
      if (wr_en && addr == A_MSK) mask_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_RAW:   rdata = raw_q;
      A_MSK:   rdata = mask_q;
      A_MIS:   rdata = masked;
      default: rdata = '0;
    endcase
  end

  for (genvar i = 0; i < 6; i++) begin : g_line
    assign irq_d[i] = |(masked & LINE_GRP[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= irq_d;
  end

  // R3
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> raw_q[TX_BIT]);

  // R4
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSK) |=> mask_q == $past(wdata));

  // R6
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR && evt_set == '0 && !data_wr) |=> (raw_q & $past(wdata)) == '0);

  // R7
  ro_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_RAW || addr == A_MIS) && evt_set == '0 && !data_wr)
      |=> raw_q == $past(raw_q));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_q & $past(evt_set)) == $past(evt_set));

  // R10
  comb_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] == |irq_o[5:1]);

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [10:0] wdata = '0;
  logic [10:0] rdata;
  logic [10:0] evt_set = '0;
  logic        data_wr = 1'b0;
  logic [5:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_set(evt_set), .data_wr(data_wr), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  // fields: evt, data_wr, wr_en, addr, wdata, exp status, exp mask, exp lines
  localparam int NV = 14;
  localparam logic [53:0] VEC [NV] = '{
    {11'h010, 1'b0, 1'b0, 2'd0, 11'h000, 11'h010, 11'h000, 6'b000000},
    {11'h000, 1'b0, 1'b1, 2'd1, 11'h7FF, 11'h010, 11'h7FF, 6'b000011},
    {11'h000, 1'b1, 1'b0, 2'd0, 11'h000, 11'h030, 11'h7FF, 6'b000111},
    {11'h201, 1'b0, 1'b0, 2'd0, 11'h000, 11'h231, 11'h7FF, 6'b110111},
    {11'h000, 1'b0, 1'b1, 2'd3, 11'h010, 11'h221, 11'h7FF, 6'b110101},
    {11'h000, 1'b0, 1'b1, 2'd0, 11'h7FF, 11'h221, 11'h7FF, 6'b110101},
    {11'h000, 1'b0, 1'b1, 2'd2, 11'h000, 11'h221, 11'h7FF, 6'b110101},
    {11'h000, 1'b0, 1'b1, 2'd1, 11'h020, 11'h221, 11'h020, 6'b000101},
    {11'h040, 1'b0, 1'b0, 2'd0, 11'h000, 11'h261, 11'h020, 6'b000101},
    {11'h000, 1'b0, 1'b1, 2'd1, 11'h040, 11'h261, 11'h040, 6'b001001},
    {11'h100, 1'b0, 1'b1, 2'd3, 11'h7FF, 11'h100, 11'h040, 6'b000000},
    {11'h000, 1'b0, 1'b1, 2'd1, 11'h180, 11'h100, 11'h180, 6'b100001},
    {11'h080, 1'b0, 1'b1, 2'd3, 11'h100, 11'h080, 11'h180, 6'b100001},
    {11'h004, 1'b0, 1'b1, 2'd1, 11'h00F, 11'h084, 11'h00F, 6'b010001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [10:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic drive(input logic [10:0] e, input logic d, input logic w,
                       input logic [1:0] a, input logic [10:0] wd);
    @(negedge clk);
    evt_set = e; data_wr = d; wr_en = w; addr = a; wdata = wd;
    @(negedge clk);
    evt_set = '0; data_wr = 1'b0; wr_en = 1'b0; wdata = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [10:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_reg(2'd0, v); check("R1 status", v, 0);
    read_reg(2'd1, v); check("R1 mask", v, 0);
    check("R1 lines", irq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][53:43], VEC[i][42], VEC[i][41], VEC[i][40:39], VEC[i][38:28]);
      @(negedge clk);
      // R2 R3 R5 R7 R8 status, R4 mask, R5 masked, R9 R10 lines
      read_reg(2'd0, v); check($sformatf("R2/R3/R7/R8 status vec %0d", i), v, VEC[i][27:17]);
      read_reg(2'd1, v); check($sformatf("R4 mask vec %0d", i), v, VEC[i][16:6]);
      read_reg(2'd2, v); check($sformatf("R5 masked vec %0d", i), v, VEC[i][27:17] & VEC[i][16:6]);
      check($sformatf("R9/R10 lines vec %0d", i), irq_o, VEC[i][5:0]);
    end

    // R6 clear register reads zero with nonzero status
    read_reg(2'd3, v); check("R6 clear reads zero", v, 0);

    // R11 lines lag status by one edge
    drive('0, 1'b0, 1'b1, 2'd3, 11'h7FF);
    drive('0, 1'b0, 1'b1, 2'd1, 11'h010);
    @(negedge clk);
    check("R11 lines idle", irq_o, 0);
    @(negedge clk);
    evt_set = 11'h010;
    @(negedge clk);
    evt_set = '0;
    read_reg(2'd0, v); check("R11 status set", v, 11'h010);
    check("R11 lines not yet", irq_o, 0);
    @(negedge clk);
    check("R11 lines one edge later", irq_o, 6'b000011);

    // R1 reset in mid-run
    rst_n = 1'b0;
    #1;
    read_reg(2'd0, v); check("R1 status after reset", v, 0);
    read_reg(2'd1, v); check("R1 mask after reset", v, 0);
    check("R1 lines after reset", irq_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule